// File: doc/BRIEF.md
# Abortable Timeout Counter

This block puts a time limit on a sub-operation that runs in other logic. A one-cycle start pulse loads the limit and arms the counter. While the counter is armed, each qualified clock tick lowers the remaining budget by one. A qualified tick is one where counting is enabled, the suspend input is low and the guarded operation has not reported completion. If the budget runs out before the operation reports done, the block raises an abort toward the guarded logic and a timeout pulse, each for one cycle, and then returns to idle.

The state one tick before expiry sits in its own one-hot flag, which is set while the budget is being decremented. The final tick therefore needs no compare on the count value, and the alarm is one flip-flop fed by that flag and the tick qualifier. Raising suspend, or dropping count enable, freezes the budget, and counting resumes from the same value. Completion from the operation disarms the counter with no alarm. A new start pulse always reloads the full limit.

Top module: `tmo_guard`

## Requirements
- R1: After reset, `armed_o`, `abort_o` and `timeout_o` are 0 and `remain_o` is 0.
- R2: A cycle with `start_i` high loads `remain_o` = LIMIT and sets `armed_o` from the next cycle. That cycle never counts as a tick.
- R3: A tick is a cycle with `armed_o`=1, `cnt_en_i`=1, `suspend_i`=0, `done_i`=0 and `start_i`=0. A tick that is not the last one lowers `remain_o` by exactly one in the next cycle.
- R4: In an armed cycle with neither start nor done, where `cnt_en_i`=0 or `suspend_i`=1, `remain_o` and `armed_o` keep their values. Counting later resumes from the held value.
- R5: The tick taken with `remain_o`=1 makes `abort_o` and `timeout_o` both 1 in the next cycle, for exactly one cycle. In that same cycle `armed_o`=0 and `remain_o`=0. This happens LIMIT ticks after the start.
- R6: `done_i`=1 in an armed cycle without start clears `armed_o` and `remain_o` in the next cycle. No abort or timeout follows.
- R7: `start_i` while armed reloads LIMIT and restarts the count. It takes priority over `done_i` and over a tick in the same cycle.
- R8: While idle, `cnt_en_i`, `suspend_i` and `done_i` have no effect: `remain_o` stays 0 and no alarm appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load the limit and arm |
| cnt_en_i | input | 1 | Allow counting this cycle |
| suspend_i | input | 1 | Freeze the count this cycle |
| done_i | input | 1 | Guarded operation completed |
| armed_o | output | 1 | Counter is running a budget |
| remain_o | output | $clog2(LIMIT+1) | Ticks left before expiry |
| abort_o | output | 1 | One-cycle abort to the guarded logic |
| timeout_o | output | 1 | One-cycle expiry indication |

## Verification
A one-hot flag that is out of step with the count would show at the ports as an alarm on the wrong tick. That could be one tick early, while `remain_o` still reads above 1, or a missing pulse when `remain_o` reaches 1. Either one appears in the cycle right after the faulty tick. A wrong choice of action (load, clear, tick or hold) shows as a `remain_o` or `armed_o` mismatch one cycle after the input pattern that caused it. The bench compares every cycle, so no fault can stay hidden for more than one clock.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_TICK  = 2'd3
  } tmo_act_e;

  // Pick the single action for this cycle; start beats done beats tick.
  function automatic tmo_act_e pick_action(input logic armed, input logic start,
                                           input logic done, input logic en,
                                           input logic susp);
    if (start)                   return ACT_LOAD;
    else if (armed && done)      return ACT_CLEAR;
    else if (armed && en && !susp) return ACT_TICK;
    else                         return ACT_HOLD;
  endfunction
endpackage

// File: rtl/tmo_ctl.sv
module tmo_ctl
  import tmo_pkg::*;
(
  input  logic     armed,
  input  logic     start_i,
  input  logic     done_i,
  input  logic     cnt_en_i,
  input  logic     suspend_i,
  output tmo_act_e act
);
  always_comb act = pick_action(armed, start_i, done_i, cnt_en_i, suspend_i);
endmodule

// File: rtl/tmo_count.sv
module tmo_count
  import tmo_pkg::*;
#(
  parameter int LIMIT = 20,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmo_act_e      act,
  output logic [CW-1:0] rem_q,
  output logic          last_q,
  output logic          armed_q
);
  function automatic logic [CW-1:0] dec1(input logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  logic final_tick;
  assign final_tick = (act == ACT_TICK) && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      last_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          rem_q   <= CW'(LIMIT);
          last_q  <= (LIMIT == 1);
          armed_q <= 1'b1;
        end
        ACT_CLEAR: begin
          rem_q   <= '0;
          last_q  <= 1'b0;
          armed_q <= 1'b0;
        end
        ACT_TICK: begin
          rem_q   <= dec1(rem_q);
          last_q  <= (int'(rem_q) == 2);
          armed_q <= !final_tick;
        end
        default: ;
      endcase
    end
  end

  AST_LAST_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> (int'(rem_q) == 1 && armed_q)) else $error("last flag out of step"); // R5
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD) |=> $stable(rem_q) && $stable(armed_q)) else $error("freeze moved count"); // R4
  AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_TICK && !last_q) |=> (rem_q == $past(rem_q) - CW'(1))) else $error("tick step"); // R3
endmodule

// File: rtl/tmo_alarm.sv
module tmo_alarm
  import tmo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tmo_act_e act,
  input  logic     last_q,
  output logic     alarm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= (act == ACT_TICK) && last_q;
  end

  AST_ALARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |=> !alarm_q) else $error("alarm longer than one cycle"); // R5
endmodule

// File: rtl/tmo_guard.sv
module tmo_guard
  import tmo_pkg::*;
#(
  parameter int LIMIT = 20,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cnt_en_i,
  input  logic          suspend_i,
  input  logic          done_i,
  output logic          armed_o,
  output logic [CW-1:0] remain_o,
  output logic          abort_o,
  output logic          timeout_o
);
  tmo_act_e      act_w;
  logic          last_w;
  logic          armed_w;
  logic          alarm_w;
  logic [CW-1:0] rem_w;

  tmo_ctl u_ctl (
    .armed(armed_w), .start_i(start_i), .done_i(done_i),
    .cnt_en_i(cnt_en_i), .suspend_i(suspend_i), .act(act_w)
  );

  tmo_count #(.LIMIT(LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .act(act_w),
    .rem_q(rem_w), .last_q(last_w), .armed_q(armed_w)
  );

  tmo_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .act(act_w), .last_q(last_w), .alarm_q(alarm_w)
  );

  assign armed_o   = armed_w;
  assign remain_o  = rem_w;
  assign abort_o   = alarm_w;
  assign timeout_o = alarm_w;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (armed_o && int'(remain_o) == LIMIT)) else $error("start did not load"); // R2
  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && done_i && !start_i) |=> (!armed_o && !abort_o && remain_o == '0)) else $error("done"); // R6
  AST_ALARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!armed_o && remain_o == '0)) else $error("alarm while armed"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !start_i) |=> (!armed_o && remain_o == '0 && !abort_o)) else $error("idle moved"); // R8
endmodule

// File: tb/tmo_guard_tb.sv
module tmo_guard_tb;
  localparam int CLK_P = 10;
  localparam int LIM   = 20;
  localparam int CW    = $clog2(LIM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, cnt_en_i = 1'b0, suspend_i = 1'b0, done_i = 1'b0;
  logic armed_o, abort_o, timeout_o;
  logic [CW-1:0] remain_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit wd_hit = 1'b0;

  bit m_arm   = 1'b0;
  int m_rem   = 0;
  bit m_alarm = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tmo_guard #(.LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_en_i(cnt_en_i),
    .suspend_i(suspend_i), .done_i(done_i), .armed_o(armed_o),
    .remain_o(remain_o), .abort_o(abort_o), .timeout_o(timeout_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Budget rule restated: start reloads, done clears, counting steps down, last step alarms.
  function automatic string step_model(input bit st, input bit en, input bit su, input bit dn);
    string tag;
    m_alarm = 1'b0;
    if (st) begin
      tag = m_arm ? "R7" : "R2";
      m_arm = 1'b1; m_rem = LIM;
    end else if (m_arm && dn) begin
      tag = "R6"; m_arm = 1'b0; m_rem = 0;
    end else if (m_arm && en && !su) begin
      if (m_rem == 1) begin tag = "R5"; m_arm = 1'b0; m_rem = 0; m_alarm = 1'b1; end
      else begin tag = "R3"; m_rem = m_rem - 1; end
    end else begin
      tag = m_arm ? "R4" : "R8";
    end
    return tag;
  endfunction

  task automatic cmp(input string tag);
    checks++;
    if (armed_o !== m_arm || int'(remain_o) != m_rem ||
        abort_o !== m_alarm || timeout_o !== m_alarm) begin
      fails++;
      $display("FAIL %s: armed/rem/abort/tmo act=%0b/%0d/%0b/%0b exp=%0b/%0d/%0b/%0b",
               tag, armed_o, remain_o, abort_o, timeout_o, m_arm, m_rem, m_alarm, m_alarm);
    end
  endtask

  task automatic cyc(input bit st, input bit en, input bit su, input bit dn);
    string tag;
    @(negedge clk);
    start_i = st; cnt_en_i = en; suspend_i = su; done_i = dn;
    @(posedge clk);
    tag = step_model(st, en, su, dn);
    #1;
    cmp(tag);
  endtask

  initial begin
    int seed;
    int held;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (armed_o !== 1'b0 || remain_o != '0 || abort_o !== 1'b0 || timeout_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset act=%0b/%0d/%0b/%0b exp=0/0/0/0", armed_o, remain_o, abort_o, timeout_o);
    end
    rst_n = 1'b1;

    // R8: idle ignores everything but start
    cyc(0, 1, 0, 1); cyc(0, 1, 1, 0); cyc(0, 1, 0, 0);
    // R2, R3, R5: full run to expiry
    cyc(1, 1, 0, 0);
    for (int i = 0; i < LIM; i++) cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    // R4: freeze by suspend and by disabled count, then resume
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
    held = int'(remain_o);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    checks++;
    if (int'(remain_o) != held) begin
      fails++; $display("FAIL R4: held act=%0d exp=%0d", remain_o, held);
    end
    for (int i = 0; i < LIM - 5; i++) cyc(0, 1, 0, 0);
    // R6: done just before the last tick
    cyc(1, 1, 0, 0);
    for (int i = 0; i < LIM - 1; i++) cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 1); cyc(0, 1, 0, 0);
    // R7: restart with done and tick in the same cycle
    cyc(1, 1, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 1);
    for (int i = 0; i < LIM + 2; i++) cyc(0, 1, 0, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit st, en, su, dn;
      st = ($urandom % 100) < 4;
      en = ($urandom % 100) < 85;
      su = ($urandom % 100) < 15;
      dn = ($urandom % 100) < 2;
      cyc(st, en, su, dn);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule